// File: doc/BRIEF.md
# Configurable Routing-and-Logic Cell

This block is one programmable cell of a fine-grained reconfigurable array. It computes and routes in the same cycle. Three input selectors pick the operands. A 3-input lookup table evaluates any Boolean function of those operands. An optional edge-triggered storage element can hold the result, and a selector then chooses either the stored value or the direct value. Three output selectors each drive either that function result or one of the three selected inputs unchanged. A single cell can therefore act as a pure wire, a fanout point, a logic gate with fanout, a gate that also forwards its operands, or a two-input gate next to an unrelated routed signal.

Operand A and operand C each come from a short diagonal link. Each of these links offers two candidate neighbours, and a 2:1 multiplexer chooses between them. Operand B comes from the vertical track. Output B drives the vertical track and outputs A and C drive diagonal links. A serial chain loads all select bits and the lookup table while configuration mode is active. The chain can be daisy-chained from cell to cell.

Top module: `rl_cell`

## Requirements
- R1: Operand A equals `dg_a0` when its diagonal select bit is 0 and `dg_a1` when it is 1. Operand C is chosen the same way from `dg_c0` and `dg_c1` by its own select bit. Operand B is always `vt_in`.
- R2: The function value is lookup bit number {C,B,A}, with C as the most significant bit, for all 256 possible tables and all 8 operand combinations.
- R3: Each output has a 2-bit select code: 00 drives the result, 01 drives operand A, 10 drives operand B and 11 drives operand C.
- R4: The result is the direct function value when the storage-mode bit is 0 and the stored value when it is 1.
- R5: The stored value takes the function value at a rising clock edge when `clk_en` is 1 and `cfg_en` is 0. In every other cycle it keeps its value, including cycles in configuration mode.
- R6: A synchronous active-high `rst` clears the stored value and all configuration bits to 0. All outputs are then 0.
- R7: While `cfg_en` is 1, each rising edge shifts in `cfg_in`. Seventeen bits make up one load. They are shifted in this order: lookup bits 0 to 7, the storage-mode bit, the A diagonal select, the C diagonal select, and then the output codes for A, B and C, each code with its high bit first. `cfg_out` shows the bit that was shifted in 17 edges earlier.
- R8: While `cfg_en` is 1, all three data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of storage and configuration |
| clk_en | input | 1 | Storage update enable |
| cfg_en | input | 1 | Configuration shift mode |
| cfg_in | input | 1 | Serial configuration input |
| cfg_out | output | 1 | Serial configuration output for the next cell |
| dg_a0 | input | 1 | Diagonal candidate 0 for operand A |
| dg_a1 | input | 1 | Diagonal candidate 1 for operand A |
| vt_in | input | 1 | Vertical track, operand B |
| dg_c0 | input | 1 | Diagonal candidate 0 for operand C |
| dg_c1 | input | 1 | Diagonal candidate 1 for operand C |
| out_a | output | 1 | Diagonal output A |
| out_b | output | 1 | Vertical output B |
| out_c | output | 1 | Diagonal output C |

## Verification
A configuration bit that lands in the wrong position shows up on the outputs as soon as the load ends. It appears either as a wrong truth-table entry or as the wrong operand on a pass-through output. Sweeping every table and every select code exposes it within one operand sweep. A bad chain order also shows directly on `cfg_out` 17 edges after the bit went in. A storage element that updates when it should hold, or that misses a reset, shows up only in storage mode. It appears one edge after the faulty update, as a result that differs from the last captured value.

// File: rtl/rl_cell.sv
module rl_cell #(
  parameter int LUT_IN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clk_en,
  input  logic cfg_en,
  input  logic cfg_in,
  output logic cfg_out,
  input  logic dg_a0,
  input  logic dg_a1,
  input  logic vt_in,
  input  logic dg_c0,
  input  logic dg_c1,
  output logic out_a,
  output logic out_b,
  output logic out_c
);
  localparam int LUT_W = 1 << LUT_IN;
  localparam int CFG_W = LUT_W + 1 + 2 + 6;

  logic [CFG_W-1:0] cfg_q;
  logic [LUT_W-1:0] lut;
  logic             store_mode, dsel_a, dsel_c;
  logic [1:0]       osel_a, osel_b, osel_c;
  logic             op_a, op_b, op_c, fn_val, store_q, res;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_en) cfg_q <= {cfg_q[CFG_W-2:0], cfg_in};
  end

  assign cfg_out = cfg_q[CFG_W-1];

  genvar k;
  generate
    for (k = 0; k < LUT_W; k++) begin : g_lut
      assign lut[k] = cfg_q[CFG_W-1-k];
    end
  endgenerate

  assign store_mode = cfg_q[8];
  assign dsel_a     = cfg_q[7];
  assign dsel_c     = cfg_q[6];
  assign osel_a     = cfg_q[5:4];
  assign osel_b     = cfg_q[3:2];
  assign osel_c     = cfg_q[1:0];

  assign op_a   = dsel_a ? dg_a1 : dg_a0;
  assign op_b   = vt_in;
  assign op_c   = dsel_c ? dg_c1 : dg_c0;
  assign fn_val = lut[{op_c, op_b, op_a}];

  always_ff @(posedge clk) begin
    if (rst)                   store_q <= 1'b0;
    else if (clk_en && !cfg_en) store_q <= fn_val;
  end

  assign res = store_mode ? store_q : fn_val;

  function automatic logic pick(input logic [1:0] code, input logic f,
                                input logic a, input logic b, input logic c);
    case (code)
      2'b00:   pick = f;
      2'b01:   pick = a;
      2'b10:   pick = b;
      default: pick = c;
    endcase
  endfunction

  assign out_a = !cfg_en && pick(osel_a, res, op_a, op_b, op_c);
  assign out_b = !cfg_en && pick(osel_b, res, op_a, op_b, op_c);
  assign out_c = !cfg_en && pick(osel_c, res, op_a, op_b, op_c);

  // R5
  store_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && (!clk_en || cfg_en)) |=> $stable(store_q));

  // R5
  store_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && clk_en && !cfg_en) |=> (store_q == $past(fn_val)));

  // R7
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && !cfg_en) |=> $stable(cfg_q));

  // R8
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_en |-> ({out_a, out_b, out_c} == 3'b000));

  // R6
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!store_q && cfg_q == '0));
endmodule

// File: tb/rl_cell_bench.sv
module rl_cell_bench;
  logic clk = 0, rst = 1, clk_en = 0, cfg_en = 0, cfg_in = 0;
  logic dg_a0 = 0, dg_a1 = 0, vt_in = 0, dg_c0 = 0, dg_c1 = 0;
  logic cfg_out, out_a, out_b, out_c;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  rl_cell u_rl_cell (
    .clk(clk), .rst(rst), .clk_en(clk_en), .cfg_en(cfg_en), .cfg_in(cfg_in),
    .cfg_out(cfg_out), .dg_a0(dg_a0), .dg_a1(dg_a1), .vt_in(vt_in),
    .dg_c0(dg_c0), .dg_c1(dg_c1), .out_a(out_a), .out_b(out_b), .out_c(out_c)
  );

  task automatic chk(input string req, input logic [2:0] got, input logic [2:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  function automatic logic [16:0] mk(input logic [7:0] lut, input logic sm,
      input logic dsa, input logic dsc, input logic [1:0] oa,
      input logic [1:0] ob, input logic [1:0] oc);
    logic [16:0] w;
    for (int k = 0; k < 8; k++) w[k] = lut[k];
    w[8] = sm; w[9] = dsa; w[10] = dsc;
    w[11] = oa[1]; w[12] = oa[0]; w[13] = ob[1];
    w[14] = ob[0]; w[15] = oc[1]; w[16] = oc[0];
    return w;
  endfunction

  function automatic logic sel(input logic [1:0] code, input logic f,
                               input logic a, input logic b, input logic c);
    return code == 0 ? f : code == 1 ? a : code == 2 ? b : c;
  endfunction

  task automatic load(input logic [16:0] w);
    for (int i = 0; i < 17; i++) begin
      @(negedge clk);
      cfg_en = 1; cfg_in = w[i];
      #1;
      if (i == 16) chk("R8", {out_a, out_b, out_c}, 3'b000);
    end
    @(negedge clk);
    cfg_en = 0; cfg_in = 0;
    #1;
  endtask

  task automatic drive(input logic [4:0] p);
    {dg_c1, dg_c0, vt_in, dg_a1, dg_a0} = p;
    #1;
  endtask

  logic exp_q;

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 0;
    #1;
    drive(5'b11111);
    chk("R6 reset state", {out_a, out_b, out_c}, 3'b000);

    // R2: every table, every operand combination; R1 mux picks 0 for A, 1 for C
    for (int t = 0; t < 256; t++) begin
      load(mk(t[7:0], 0, 0, 1, 2'b00, 2'b01, 2'b11));
      for (int v = 0; v < 8; v++) begin
        logic a, b, c, f;
        a = v[0]; b = v[1]; c = v[2];
        drive({c, ~c, b, ~a, a});
        f = t[{c, b, a}];
        chk("R2 lut", {out_a, out_b, out_c}, {f, a, c});
      end
    end

    // R1 R3: all select codes and diagonal choices, majority table
    for (int code = 0; code < 4; code++)
      for (int ds = 0; ds < 4; ds++) begin
        logic [1:0] oa, ob, oc;
        oa = code[1:0]; ob = 2'(code + 1); oc = 2'(code + 2);
        load(mk(8'hE8, 0, ds[0], ds[1], oa, ob, oc));
        for (int p = 0; p < 32; p++) begin
          logic a, b, c, f;
          drive(p[4:0]);
          a = ds[0] ? p[1] : p[0];
          b = p[2];
          c = ds[1] ? p[4] : p[3];
          f = (a & b) | (a & c) | (b & c);
          chk("R1 R3 route", {out_a, out_b, out_c},
              {sel(oa, f, a, b, c), sel(ob, f, a, b, c), sel(oc, f, a, b, c)});
        end
      end

    // R4 R5: storage mode, xor table, A from dg_a0, C from dg_c0
    exp_q = 0;
    load(mk(8'h96, 1, 0, 0, 2'b00, 2'b00, 2'b01));
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      {dg_c0, vt_in, dg_a0} = v[2:0]; clk_en = 1;
      #1;
      chk("R4 before edge", {out_a, out_b, out_c}, {exp_q, exp_q, v[0]});
      @(negedge clk);
      exp_q = ^v[2:0];
      #1;
      chk("R5 capture", {out_a, out_b, out_c}, {exp_q, exp_q, v[0]});
    end
    @(negedge clk);
    clk_en = 0; {dg_c0, vt_in, dg_a0} = 3'b001;
    repeat (3) @(negedge clk);
    #1;
    chk("R5 hold no enable", {out_a, out_b}, {exp_q, exp_q});
    clk_en = 1;
    load(mk(8'h96, 1, 0, 0, 2'b00, 2'b00, 2'b00));
    clk_en = 0;
    chk("R5 hold in config", {out_a, out_b, out_c}, {3{exp_q}});
    load(mk(8'h96, 0, 0, 0, 2'b00, 2'b00, 2'b00));
    chk("R4 direct", {out_a, out_b, out_c}, 3'b111);

    // R6: set stored value to 1, reset, then confirm cleared
    load(mk(8'h96, 1, 0, 0, 2'b00, 2'b00, 2'b00));
    @(negedge clk); clk_en = 1;
    @(negedge clk); clk_en = 0; #1;
    chk("R6 pre", {out_a, out_b, out_c}, 3'b111);
    rst = 1;
    @(negedge clk); rst = 0; #1;
    chk("R6 config cleared", {out_a, out_b, out_c}, 3'b000);
    load(mk(8'h96, 1, 0, 0, 2'b00, 2'b00, 2'b00));
    chk("R6 storage cleared", {out_a, out_b, out_c}, 3'b000);

    // R7: chain order and 17-edge delay
    begin
      logic [16:0] w;
      w = 17'h1B2C5;
      load(w);
      for (int i = 0; i < 17; i++) begin
        @(negedge clk);
        cfg_en = 1; cfg_in = 0;
        #1;
        chk("R7 cfg_out", {2'b00, cfg_out}, {2'b00, w[i]});
      end
      @(negedge clk); cfg_en = 0; #1;
      chk("R7 drained", {out_a, out_b, out_c}, 3'b000);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule